// File: doc/BRIEF.md
# Snoop Invalidation Monitor

This block keeps a cache coherent with a shared system bus that other masters can write to. It watches every bus write strobe. When monitoring is on and the writer is not the host processor, it places the written address in a small queue. An idle service engine takes the oldest queued address and asks the cache controller for a slot on the tag array. It then reads the tag entry that the address indexes. If that entry is valid and its stored tag equals the upper address bits, the engine clears the entry's valid bit. If not, the engine discards the address and changes nothing.

The queue is two entries deep by default. If a foreign write arrives while the queue is full and no entry leaves in that cycle, the address is dropped. A one-cycle flush request then tells the cache controller to clear the whole cache, so stale data cannot survive. Two diagnostic controls are provided:
- a loopback control, which lets host writes be captured as well;
- a hold control, which stops the engine from starting new tag accesses.

The tag read latency is a parameter: 0 for a combinational read, 1 for a registered read.

Top module: `snoop_inval_mon`

## Requirements
- R1: After reset, `tag_req`, `inv_we` and `flush_req` are all low, and the queue is empty.
- R2: A write strobe with `cfg_mon_en` high and `bus_from_host` low is queued. With `cfg_loopback` low, a write from the host is ignored and leaves every tag entry unchanged.
- R3: A capturable write that finds the queue full, in a cycle where no entry leaves, is dropped. `flush_req` goes high for one cycle, on the clock edge after that write.
- R4: A queued address whose indexed entry reads valid and has a matching tag is a monitor hit. The engine asserts `inv_we` with `inv_idx` equal to that index for exactly one cycle.
- R5: A queued address whose indexed entry has a different tag, or is already invalid, leaves the queue with no `inv_we`.
- R6: Queued addresses are serviced in the order they were captured.
- R7: With `cfg_mon_en` low, no write is captured and no entry is changed.
- R8: With `cfg_loopback` high, host writes are captured and serviced like foreign writes.
- R9: While `cfg_hold` is high, the engine starts no new tag request. Entries wait in the queue and are serviced after `cfg_hold` falls.
- R10: `tag_req` stays high until `tag_gnt` is seen. With READ_LAT=1, the tag data is sampled on the cycle after the grant. Each queued entry is popped in the cycle its compare completes.
- R11: The bit fields of `bus_addr` are:
  - bits `[OFS+IDX_W-1:OFS]` (bits 13:2 by default) form the index;
  - bits `[AW-1:OFS+IDX_W]` (bits 31:14) form the tag;
  - the low OFS bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mon_en | input | 1 | Monitoring enable |
| cfg_loopback | input | 1 | Diagnostic: capture host writes too |
| cfg_hold | input | 1 | Diagnostic: stall queue servicing |
| bus_wr_stb | input | 1 | One-cycle pulse per bus write |
| bus_from_host | input | 1 | Current write comes from the host processor |
| bus_addr | input | AW | Byte address of the bus write |
| tag_req | output | 1 | Request for a tag-array slot |
| tag_gnt | input | 1 | Slot granted by the cache controller |
| tag_idx | output | IDX_W | Index of the tag entry to read |
| tag_rd_tag | input | AW-IDX_W-OFS | Stored tag of the indexed entry |
| tag_rd_vld | input | 1 | Valid bit of the indexed entry |
| inv_we | output | 1 | Clear the valid bit at `inv_idx` |
| inv_idx | output | IDX_W | Index to invalidate |
| flush_req | output | 1 | Pulse: invalidate the whole cache |

## Verification
The assertions rely on a few assumptions about the environment:
- `bus_wr_stb` is a clean synchronous pulse.
- The cache controller returns tag data exactly READ_LAT cycles after a grant.
- The controller does not change the entry being compared during that window.

The stimulus keeps to these assumptions:
- Each write is driven on a falling edge for exactly one cycle.
- The bench's own tag array registers its read on the grant edge.
- Invalidations are applied only to indices that no other queued address targets while that entry is in flight.

Grants are either held high or held low for whole phases, so a request is never withdrawn in the middle of a compare.

// File: rtl/snp_pkg.sv
package snp_pkg;
   typedef enum logic [1:0] {
      SVC_IDLE = 2'd0,
      SVC_REQ  = 2'd1,
      SVC_RD   = 2'd2
   } svc_state_e;
endpackage

// File: rtl/snp_capture.sv
module snp_capture #(
   parameter int AW     = 32,
   parameter int OFS    = 2,
   parameter bit IN_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mon_en,
   input  logic              cfg_loopback,
   input  logic              bus_wr_stb,
   input  logic              bus_from_host,
   input  logic [AW-1:0]     bus_addr,
   output logic              push,
   output logic [AW-OFS-1:0] push_addr
);
   localparam int QW = AW - OFS;

   logic          take;
   logic [QW-1:0] word_addr;

   // qualify: enabled, and either a foreign master or loopback diagnostics
   assign take      = cfg_mon_en && bus_wr_stb && (!bus_from_host || cfg_loopback);
   assign word_addr = bus_addr[AW-1:OFS];

   generate
      if (IN_REG) begin : g_reg
         logic          take_q;
         logic [QW-1:0] addr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               take_q <= 1'b0;
               addr_q <= '0;
            end else begin
               take_q <= take;
               addr_q <= word_addr;
            end
         end
         assign push      = take_q;
         assign push_addr = addr_q;
      end else begin : g_comb
         assign push      = take;
         assign push_addr = word_addr;
      end
   endgenerate

   p_mon_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_mon_en && !IN_REG) |-> !push);
endmodule

// File: rtl/snp_fifo.sv
module snp_fifo #(
   parameter int W     = 30,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full,
   output logic         ovf
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
   localparam logic [CW-1:0] FULLC = CW'(DEPTH);

   initial begin
      assert (DEPTH >= 2) else $error("snp_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == FULLC);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign ovf     = push && full && !do_pop;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   p_ovf_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> full);
   p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULLC);
endmodule

// File: rtl/snp_service.sv
module snp_service
   import snp_pkg::*;
#(
   parameter int IDX_W    = 12,
   parameter int TAG_W    = 18,
   parameter int READ_LAT = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   head_vld,
   input  logic [TAG_W+IDX_W-1:0] head_addr,
   input  logic                   cfg_hold,
   output logic                   tag_req,
   input  logic                   tag_gnt,
   output logic [IDX_W-1:0]       tag_idx,
   input  logic [TAG_W-1:0]       tag_rd_tag,
   input  logic                   tag_rd_vld,
   output logic                   inv_we,
   output logic [IDX_W-1:0]       inv_idx,
   output logic                   pop
);
   initial begin
      assert (READ_LAT == 0 || READ_LAT == 1)
         else $error("snp_service: READ_LAT must be 0 or 1");
   end

   svc_state_e       st, nxt;
   logic             slot_done, go_rd, hit;
   logic [IDX_W-1:0] head_idx;
   logic [TAG_W-1:0] head_tag;

   assign head_idx = head_addr[IDX_W-1:0];
   assign head_tag = head_addr[TAG_W+IDX_W-1:IDX_W];

   generate
      if (READ_LAT == 0) begin : g_lat0
         assign slot_done = (st == SVC_REQ) && tag_gnt;
         assign go_rd     = 1'b0;
      end else begin : g_lat1
         assign slot_done = (st == SVC_RD);
         assign go_rd     = (st == SVC_REQ) && tag_gnt;
      end
   endgenerate

   always_comb begin
      nxt = st;
      case (st)
         SVC_IDLE: if (head_vld && !cfg_hold) nxt = SVC_REQ;
         SVC_REQ: begin
            if (slot_done)     nxt = SVC_IDLE;
            else if (go_rd)    nxt = SVC_RD;
            else if (cfg_hold) nxt = SVC_IDLE;
         end
         SVC_RD:   nxt = SVC_IDLE;
         default:  nxt = SVC_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= SVC_IDLE;
      else        st <= nxt;
   end

   assign hit     = tag_rd_vld && (tag_rd_tag == head_tag);
   assign tag_req = (st == SVC_REQ) || (st == SVC_RD);
   assign tag_idx = head_idx;
   assign inv_we  = slot_done && hit;
   assign inv_idx = head_idx;
   assign pop     = slot_done;

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_req && !tag_gnt && !cfg_hold && !pop) |=> tag_req);
   p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hold && !tag_req) |=> !tag_req);
   p_inv_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      inv_we |=> !inv_we);
   p_inv_in_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      inv_we |-> (tag_req && head_vld));
   p_pop_in_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> tag_req);
endmodule

// File: rtl/snoop_inval_mon.sv
module snoop_inval_mon #(
   parameter int AW       = 32,
   parameter int OFS      = 2,
   parameter int IDX_W    = 12,
   parameter int DEPTH    = 2,
   parameter int READ_LAT = 1,
   parameter bit IN_REG   = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_mon_en,
   input  logic                    cfg_loopback,
   input  logic                    cfg_hold,
   input  logic                    bus_wr_stb,
   input  logic                    bus_from_host,
   input  logic [AW-1:0]           bus_addr,
   output logic                    tag_req,
   input  logic                    tag_gnt,
   output logic [IDX_W-1:0]        tag_idx,
   input  logic [AW-IDX_W-OFS-1:0] tag_rd_tag,
   input  logic                    tag_rd_vld,
   output logic                    inv_we,
   output logic [IDX_W-1:0]        inv_idx,
   output logic                    flush_req
);
   localparam int TAG_W = AW - IDX_W - OFS;
   localparam int QW    = AW - OFS;

   initial begin
      assert (TAG_W >= 1) else $error("snoop_inval_mon: AW too small for IDX_W and OFS");
   end

   logic          push, pop, empty, full, ovf;
   logic [QW-1:0] push_addr, head_addr;

   snp_capture #(.AW(AW), .OFS(OFS), .IN_REG(IN_REG)) u_cap (
      .clk(clk), .rst_n(rst_n),
      .cfg_mon_en(cfg_mon_en), .cfg_loopback(cfg_loopback),
      .bus_wr_stb(bus_wr_stb), .bus_from_host(bus_from_host), .bus_addr(bus_addr),
      .push(push), .push_addr(push_addr)
   );

   snp_fifo #(.W(QW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(push), .din(push_addr), .pop(pop),
      .dout(head_addr), .empty(empty), .full(full), .ovf(ovf)
   );

   snp_service #(.IDX_W(IDX_W), .TAG_W(TAG_W), .READ_LAT(READ_LAT)) u_svc (
      .clk(clk), .rst_n(rst_n),
      .head_vld(!empty), .head_addr(head_addr), .cfg_hold(cfg_hold),
      .tag_req(tag_req), .tag_gnt(tag_gnt), .tag_idx(tag_idx),
      .tag_rd_tag(tag_rd_tag), .tag_rd_vld(tag_rd_vld),
      .inv_we(inv_we), .inv_idx(inv_idx), .pop(pop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flush_req <= 1'b0;
      else        flush_req <= ovf;
   end

   p_flush_after_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> full);
   p_push_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !IN_REG) |-> (cfg_mon_en && (!bus_from_host || cfg_loopback)));
endmodule

// File: tb/snoop_inval_mon_bench.sv
module snoop_inval_mon_bench;
   localparam int AW = 32, OFS = 2, IDX_W = 12, TW = AW - IDX_W - OFS;
   localparam int N = 1 << IDX_W;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_mon_en = 1'b0, cfg_loopback = 1'b0, cfg_hold = 1'b0;
   logic bus_wr_stb = 1'b0, bus_from_host = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic tag_req, tag_gnt = 1'b1, inv_we, flush_req;
   logic [IDX_W-1:0] tag_idx, inv_idx;
   logic [TW-1:0] tag_rd_tag = '0;
   logic tag_rd_vld = 1'b0;

   logic [TW-1:0] bm_tag [N];
   logic          bm_vld [N];
   logic          ref_vld [N];
   logic          bm_clr [N] = '{default: 1'b0};

   int checks = 0, errors = 0, flushes = 0;
   int unsigned exp_q [$];
   bit done = 1'b0;

   always #5 clk = ~clk;

   snoop_inval_mon u_snoop_inval_mon (
      .clk(clk), .rst_n(rst_n), .cfg_mon_en(cfg_mon_en), .cfg_loopback(cfg_loopback),
      .cfg_hold(cfg_hold), .bus_wr_stb(bus_wr_stb), .bus_from_host(bus_from_host),
      .bus_addr(bus_addr), .tag_req(tag_req), .tag_gnt(tag_gnt), .tag_idx(tag_idx),
      .tag_rd_tag(tag_rd_tag), .tag_rd_vld(tag_rd_vld), .inv_we(inv_we),
      .inv_idx(inv_idx), .flush_req(flush_req)
   );

   // tag array model: registered read on grant, invalidation at the edge
   always @(posedge clk) begin
      if (tag_req && tag_gnt) begin
         tag_rd_tag <= bm_tag[tag_idx];
         tag_rd_vld <= bm_vld[tag_idx] && !bm_clr[tag_idx];
      end
      if (inv_we) bm_clr[inv_idx] <= 1'b1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (flush_req) flushes++;
         if (inv_we) begin
            if (exp_q.size() == 0) check(1'b0, "R5 unexpected invalidation", inv_idx, 0);
            else begin
               int unsigned e;
               e = exp_q.pop_front();
               check(inv_idx == IDX_W'(e), "R4/R6 invalidation index", inv_idx, e);
            end
         end
      end
   end

   function automatic bit vld_now(input int i);
      return bm_vld[i] && !bm_clr[i];
   endfunction

   task automatic snoop_wr(input logic [TW-1:0] t, input int i, input bit host, input bit drop);
      bit cap;
      cap = cfg_mon_en && (!host || cfg_loopback);
      if (cap && !drop && ref_vld[i] && bm_tag[i] == t) begin
         exp_q.push_back(i);
         ref_vld[i] = 1'b0;
      end
      @(negedge clk);
      bus_wr_stb    = 1'b1;
      bus_from_host = host;
      bus_addr      = {t, IDX_W'(i), 2'b11};
      @(negedge clk);
      bus_wr_stb    = 1'b0;
      bus_from_host = 1'b0;
   endtask

   task automatic settle();
      repeat (20) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < N; k++) begin
         bm_tag[k] = TW'(k * 7 + 3);
         bm_vld[k] = 1'b1;
         ref_vld[k] = 1'b1;
      end
      bm_tag[12'h020] = 18'h11111;
      bm_vld[12'h030] = 1'b0; ref_vld[12'h030] = 1'b0;
      bm_tag[12'hFFF] = 18'h3FFFF;
      bm_tag[12'h000] = 18'h00000;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(tag_req == 1'b0, "R1 tag_req", tag_req, 0);
      check(inv_we == 1'b0, "R1 inv_we", inv_we, 0);
      check(flush_req == 1'b0, "R1 flush_req", flush_req, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(tag_req == 1'b0, "R1 queue empty, no request", tag_req, 0);

      cfg_mon_en = 1'b1;
      // R2 R4 R11 foreign hit, including index boundaries
      snoop_wr(bm_tag[12'h010], 12'h010, 1'b0, 1'b0); settle();
      check(!vld_now(12'h010), "R4 entry cleared", vld_now(12'h010), 0);
      snoop_wr(18'h3FFFF, 12'hFFF, 1'b0, 1'b0); settle();
      check(!vld_now(12'hFFF), "R11 top index/tag", vld_now(12'hFFF), 0);
      snoop_wr(18'h00000, 12'h000, 1'b0, 1'b0); settle();
      check(!vld_now(12'h000), "R11 zero index", vld_now(12'h000), 0);
      // R5 misses
      snoop_wr(18'h22222, 12'h020, 1'b0, 1'b0); settle();
      check(vld_now(12'h020), "R5 tag mismatch keeps entry", vld_now(12'h020), 1);
      snoop_wr(bm_tag[12'h030], 12'h030, 1'b0, 1'b0); settle();
      check(tag_req == 1'b0, "R5 invalid entry popped", tag_req, 0);
      // R2 host write ignored
      snoop_wr(bm_tag[12'h040], 12'h040, 1'b1, 1'b0); settle();
      check(vld_now(12'h040), "R2 host write ignored", vld_now(12'h040), 1);
      // R7 monitor disabled
      cfg_mon_en = 1'b0;
      snoop_wr(bm_tag[12'h050], 12'h050, 1'b0, 1'b0); settle();
      check(vld_now(12'h050), "R7 disabled ignores", vld_now(12'h050), 1);
      cfg_mon_en = 1'b1;
      // R8 loopback
      cfg_loopback = 1'b1;
      snoop_wr(bm_tag[12'h060], 12'h060, 1'b1, 1'b0); settle();
      check(!vld_now(12'h060), "R8 loopback host captured", vld_now(12'h060), 0);
      cfg_loopback = 1'b0;
      // R9 hold
      cfg_hold = 1'b1;
      snoop_wr(bm_tag[12'h070], 12'h070, 1'b0, 1'b0);
      for (int c = 0; c < 15; c++) begin
         @(negedge clk);
         if (tag_req) check(1'b0, "R9 request during hold", tag_req, 0);
      end
      check(vld_now(12'h070), "R9 entry untouched during hold", vld_now(12'h070), 1);
      cfg_hold = 1'b0; settle();
      check(!vld_now(12'h070), "R9 serviced after release", vld_now(12'h070), 0);
      // R3 R6 R10 overflow with grant withheld
      tag_gnt = 1'b0;
      snoop_wr(bm_tag[12'h080], 12'h080, 1'b0, 1'b0);
      snoop_wr(bm_tag[12'h081], 12'h081, 1'b0, 1'b0);
      snoop_wr(bm_tag[12'h082], 12'h082, 1'b0, 1'b1);
      repeat (5) @(negedge clk);
      check(tag_req == 1'b1, "R10 request held without grant", tag_req, 1);
      check(flushes == 1, "R3 flush pulse count", flushes, 1);
      check(vld_now(12'h080), "R10 nothing before grant", vld_now(12'h080), 1);
      tag_gnt = 1'b1; settle();
      check(!vld_now(12'h081), "R6 second entry serviced", vld_now(12'h081), 0);
      check(vld_now(12'h082), "R3 dropped address untouched", vld_now(12'h082), 1);
      check(exp_q.size() == 0, "R4 all expected invalidations seen", exp_q.size(), 0);
      check(flushes == 1, "R3 single flush", flushes, 1);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule